// File: doc/BRIEF.md
# Pair-shifted instruction queue

This block sits between instruction fetch and dispatch and holds up to eight instructions. Fetch offers a group of up to four instructions per cycle, in program order, together with a count. The group is taken whole or not at all. Dispatch sees the four oldest entry positions as a window, with a valid bit per position. Each cycle it reports how many of the valid window instructions it consumed, from zero to four, always the oldest first.

Storage is organised as four two-entry pairs. Contents move toward the head only a whole pair at a time. A pair leaves the head only when both of its instructions are gone. If only its first instruction has been consumed, the pair stays in place with that half marked invalid. This keeps the shift network to a few pair-wide choices instead of a per-entry compactor. The cost is that a half-used head pair can keep one entry of capacity out of use for a while.

A flush input empties the queue in one cycle. Flush overrides any fetch or dispatch in that same cycle.

Top module: `psiq_top`

## Requirements
- R1: After reset the queue is empty: `dispValid` is 0, and `fetchReady` is 1 for every count from 0 to 4.
- R2: The queue never holds more than 8 instructions. `fetchReady` is 1 only when the number of entries from the tail position to the end of storage is at least `fetchCount`. A group offered while `fetchReady` is 0 is not written, in whole or in part.
- R3: A `fetchCount` greater than 4 is never accepted: `fetchReady` is 0 for it.
- R4: `dispValid[i]` and `dispData[i*32 +: 32]` describe entry position i, with position 0 the oldest. Position i holds a younger instruction than position i-1. Fetch lane k (`fetchData[k*32 +: 32]`, k below `fetchCount`) is the k-th instruction of the group in program order.
- R5: `dispTake` removes the oldest min(`dispTake`, number of valid window entries) valid window instructions, in program order. Any request beyond the valid count has no effect.
- R6: A pair (positions 2p and 2p+1) moves out only when both of its instructions have been consumed. When only the first half of the head pair is consumed, the next cycle shows `dispValid[0]`=0 and `dispValid[1]`=1, with the second instruction still at position 1. An invalid window position is never followed by a valid one, except at position 0.
- R7: Removal, the pair shift and the fetch write all happen in the same cycle. The group is placed directly after the youngest remaining instruction, once the shift is done. `fetchReady` is judged on the contents held before that cycle's dispatch.
- R8: `flushIn` empties the queue in the next cycle and overrides a fetch or a dispatch in the same cycle.
- R9: When every held instruction has been consumed, the tail returns to position 0, so the next group begins at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flushIn | input | 1 | Empty the queue at the next edge |
| fetchValid | input | 1 | A fetch group is offered |
| fetchCount | input | 3 | Number of instructions in the group (0 to 4) |
| fetchData | input | 128 | Group lanes, lane 0 oldest |
| fetchReady | output | 1 | The offered group fits and will be taken |
| dispTake | input | 3 | Number of valid window instructions consumed this cycle |
| dispValid | output | 4 | Valid bit per window position, bit 0 oldest |
| dispData | output | 128 | Window instructions, position 0 in the low bits |

## Verification
The two functions that collide are the dispatch removal with its pair shift and the fetch write. Both can land in one cycle, and the group's position then depends on how many pairs the removal freed.

The bench provokes this directly. It fills the queue to within a few entries of full, dispatches a count that frees one pair or leaves a half pair, and offers a group in that same cycle. It also crosses fetch and dispatch with flush, and then runs a long random mix of counts, take values and rare flushes.

Every cycle a queue-based reference model predicts `fetchReady`, all valid bits and every valid window word. The model works from pre-dispatch occupancy and placement after the shift. Any disagreement is a failure.

// File: rtl/psiq_pkg.sv
package psiq_pkg;
  // Width of the strobe fields; supports queues up to 255 entries.
  localparam int PTR_W = 8;

  // Control-to-datapath strobes for one cycle.
  typedef struct packed {
    logic             flush;       // clear storage
    logic             wrEn;        // write the fetch group
    logic [PTR_W-1:0] shiftPairs;  // pairs moved toward the head
    logic [PTR_W-1:0] wrBase;      // first entry written, after the shift
    logic [PTR_W-1:0] wrCount;     // lanes written
  } psiq_strobe_t;
endpackage

// File: rtl/psiq_ctrl.sv
module psiq_ctrl
  import psiq_pkg::*;
#(
  parameter int PAIRS   = 4,
  parameter int FETCH_W = 4,
  parameter int WIN     = 4,
  localparam int ENTRIES = 2 * PAIRS,
  localparam int IDX_W   = $clog2(ENTRIES + 1),
  localparam int CNT_W   = $clog2(FETCH_W + 1),
  localparam int TAKE_W  = $clog2(WIN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushIn,
  input  logic              fetchValid,
  input  logic [CNT_W-1:0]  fetchCount,
  output logic              fetchReady,
  input  logic [TAKE_W-1:0] dispTake,
  output logic [WIN-1:0]    winValid,
  output psiq_strobe_t      strobe
);

  logic [ENTRIES-1:0] validQ, validNext;
  logic [IDX_W-1:0]   tailQ, tailNext;
  logic [ENTRIES-1:0] vMid, vShift;
  logic               accept, found;
  int freeCnt, grpCnt, takeEff, winCnt, seen, lead, tailMid, tailSum;

  always_comb begin
    // Admission judged on the contents held before this cycle's dispatch.
    freeCnt    = ENTRIES - int'(tailQ);
    grpCnt     = int'(fetchCount);
    fetchReady = (grpCnt <= FETCH_W) && (grpCnt <= freeCnt);
    accept     = fetchValid && fetchReady && !flushIn;

    // Remove the oldest valid window entries, clamped to what is there.
    winCnt  = $countones(validQ[WIN-1:0]);
    takeEff = int'(dispTake);
    if (takeEff > winCnt) takeEff = winCnt;
    vMid = validQ;
    seen = 0;
    for (int i = 0; i < WIN; i++) begin
      if (validQ[i] && (seen < takeEff)) begin
        vMid[i] = 1'b0;
        seen    = seen + 1;
      end
    end

    // Count fully consumed pairs at the head.
    lead  = 0;
    found = 1'b0;
    for (int p = 0; p < PAIRS; p++) begin
      if (!found) begin
        if (!vMid[2*p] && !vMid[2*p+1]) lead = lead + 1;
        else found = 1'b1;
      end
    end
    if (vMid == '0) begin
      lead    = 0;
      tailMid = 0;
    end else begin
      tailMid = int'(tailQ) - 2 * lead;
    end

    vShift = '0;
    for (int j = 0; j < ENTRIES; j++) begin
      if (j + 2 * lead < ENTRIES) vShift[j] = vMid[j + 2 * lead];
    end

    // Append the group after the shifted tail.
    validNext = vShift;
    if (accept) begin
      for (int j = 0; j < ENTRIES; j++) begin
        if ((j >= tailMid) && (j < tailMid + grpCnt)) validNext[j] = 1'b1;
      end
    end
    tailSum = tailMid + (accept ? grpCnt : 0);
    tailNext = IDX_W'(tailSum);
    if (flushIn) begin
      validNext = '0;
      tailNext  = '0;
    end

    strobe.flush      = flushIn;
    strobe.wrEn       = accept;
    strobe.shiftPairs = PTR_W'(lead);
    strobe.wrBase     = PTR_W'(tailMid);
    strobe.wrCount    = PTR_W'(grpCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      tailQ  <= '0;
    end else begin
      validQ <= validNext;
      tailQ  <= tailNext;
    end
  end

  assign winValid = validQ[WIN-1:0];

endmodule

// File: rtl/psiq_data.sv
module psiq_data
  import psiq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PAIRS   = 4,
  parameter int FETCH_W = 4,
  parameter int WIN     = 4,
  localparam int ENTRIES = 2 * PAIRS
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  psiq_strobe_t              strobe,
  input  logic [FETCH_W*DATA_W-1:0] fetchData,
  output logic [WIN*DATA_W-1:0]     winData
);

  logic [DATA_W-1:0] memQ    [ENTRIES];
  logic [DATA_W-1:0] memNext [ENTRIES];

  always_comb begin
    for (int j = 0; j < ENTRIES; j++) begin
      memNext[j] = '0;
      // Pair-granular move toward the head.
      for (int s = 0; s <= PAIRS; s++) begin
        if ((int'(strobe.shiftPairs) == s) && (j + 2 * s < ENTRIES))
          memNext[j] = memQ[j + 2 * s];
      end
      // Fetch lanes land at and after the shifted tail.
      if (strobe.wrEn) begin
        for (int k = 0; k < FETCH_W; k++) begin
          if ((k < int'(strobe.wrCount)) && (j == int'(strobe.wrBase) + k))
            memNext[j] = fetchData[k*DATA_W +: DATA_W];
        end
      end
      if (strobe.flush) memNext[j] = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < ENTRIES; j++) memQ[j] <= '0;
    end else begin
      for (int j = 0; j < ENTRIES; j++) memQ[j] <= memNext[j];
    end
  end

  for (genvar w = 0; w < WIN; w++) begin : g_win
    assign winData[w*DATA_W +: DATA_W] = memQ[w];
  end

endmodule

// File: rtl/psiq_top.sv
module psiq_top
  import psiq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PAIRS   = 4,
  parameter int FETCH_W = 4,
  parameter int WIN     = 4,
  localparam int CNT_W  = $clog2(FETCH_W + 1),
  localparam int TAKE_W = $clog2(WIN + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      flushIn,
  input  logic                      fetchValid,
  input  logic [CNT_W-1:0]          fetchCount,
  input  logic [FETCH_W*DATA_W-1:0] fetchData,
  output logic                      fetchReady,
  input  logic [TAKE_W-1:0]         dispTake,
  output logic [WIN-1:0]            dispValid,
  output logic [WIN*DATA_W-1:0]     dispData
);

  psiq_strobe_t strobe;

  psiq_ctrl #(.PAIRS(PAIRS), .FETCH_W(FETCH_W), .WIN(WIN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .flushIn    (flushIn),
    .fetchValid (fetchValid),
    .fetchCount (fetchCount),
    .fetchReady (fetchReady),
    .dispTake   (dispTake),
    .winValid   (dispValid),
    .strobe     (strobe)
  );

  psiq_data #(.DATA_W(DATA_W), .PAIRS(PAIRS), .FETCH_W(FETCH_W), .WIN(WIN)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .fetchData (fetchData),
    .winData   (dispData)
  );

endmodule

// File: rtl/psiq_chk.sv
module psiq_chk #(
  parameter int FETCH_W = 4,
  parameter int WIN     = 4,
  localparam int CNT_W  = $clog2(FETCH_W + 1),
  localparam int TAKE_W = $clog2(WIN + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              flushIn,
  input logic              fetchValid,
  input logic [CNT_W-1:0]  fetchCount,
  input logic              fetchReady,
  input logic [TAKE_W-1:0] dispTake,
  input logic [WIN-1:0]    dispValid
);

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid == '0 && int'(fetchCount) <= FETCH_W) |-> fetchReady); // R1

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !fetchReady && !flushIn && dispTake == '0) |=> $stable(dispValid)); // R2

  AST_OVERSIZE_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    (int'(fetchCount) > FETCH_W) |-> !fetchReady); // R3

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flushIn |=> (dispValid == '0)); // R8

  for (genvar i = 1; i < WIN - 1; i++) begin : g_hole
    AST_HOLE_AT_HEAD: assert property (@(posedge clk) disable iff (!rstN)
      !dispValid[i] |-> !dispValid[i+1]); // R6
  end

endmodule

bind psiq_top psiq_chk #(.FETCH_W(FETCH_W), .WIN(WIN)) u_chk (.*);

// File: tb/tb_psiq_top.sv
module tb_psiq_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         flushIn = 1'b0;
  logic         fetchValid = 1'b0;
  logic [2:0]   fetchCount = '0;
  logic [127:0] fetchData = '0;
  logic         fetchReady;
  logic [2:0]   dispTake = '0;
  logic [3:0]   dispValid;
  logic [127:0] dispData;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int seqNo = 1;
  bit done = 0;

  // Reference model: occupied slots in program order, with a valid flag each.
  logic [31:0] mD[$];
  bit          mV[$];

  always #5 clk = ~clk;

  psiq_top dut (
    .clk(clk), .rstN(rstN), .flushIn(flushIn), .fetchValid(fetchValid),
    .fetchCount(fetchCount), .fetchData(fetchData), .fetchReady(fetchReady),
    .dispTake(dispTake), .dispValid(dispValid), .dispData(dispData)
  );

  task automatic check(input string tag, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit fv, input int fc, input int take,
                      input bit fl);
    bit          expReady;
    logic [3:0]  expV;
    logic [127:0] expD, actD;
    int          winCnt, takeEff, removed;
    @(negedge clk);
    flushIn    = fl;
    fetchValid = fv;
    fetchCount = 3'(fc);
    dispTake   = 3'(take);
    for (int k = 0; k < 4; k++) fetchData[k*32 +: 32] = 32'(seqNo + k);
    #1;
    expReady = (fc <= 4) && (8 - mD.size() >= fc);
    expV = '0; expD = '0; actD = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < mD.size() && mV[i]) begin
        expV[i] = 1'b1;
        expD[i*32 +: 32] = mD[i];
        actD[i*32 +: 32] = dispData[i*32 +: 32];
      end
    end
    check(tag, "fetchReady", 128'(fetchReady), 128'(expReady));
    check(tag, "dispValid", 128'(dispValid), 128'(expV));
    check(tag, "dispData", actD, expD);
    // Model update for this edge.
    if (fl) begin
      mD.delete(); mV.delete();
    end else begin
      winCnt = $countones(expV);
      takeEff = (take > winCnt) ? winCnt : take;
      removed = 0;
      for (int i = 0; i < 4 && i < mD.size(); i++) begin
        if (mV[i] && removed < takeEff) begin
          mV[i] = 0;
          removed++;
        end
      end
      begin
        bit any = 0;
        foreach (mV[i]) if (mV[i]) any = 1;
        if (!any) begin
          mD.delete(); mV.delete();
        end else begin
          while (mD.size() >= 2 && !mV[0] && !mV[1]) begin
            void'(mD.pop_front()); void'(mD.pop_front());
            void'(mV.pop_front()); void'(mV.pop_front());
          end
        end
      end
      if (fv && expReady) begin
        for (int k = 0; k < fc; k++) begin
          mD.push_back(32'(seqNo + k));
          mV.push_back(1'b1);
        end
        seqNo += fc;
      end
    end
    @(posedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<50000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: empty after reset, ready for a full group
    step("R1", 1'b0, 4, 0, 1'b0);
    step("R1", 1'b1, 4, 0, 1'b0);
    step("R4", 1'b1, 3, 0, 1'b0);
    // R2: 7 held, group of 2 does not fit
    step("R2", 1'b1, 2, 0, 1'b0);
    step("R2", 1'b0, 0, 0, 1'b0);
    // R6: fill last entry and consume one -> half pair at head
    step("R6", 1'b1, 1, 1, 1'b0);
    step("R6", 1'b1, 1, 0, 1'b0);
    // R7: second half consumed frees a pair; ready still judged on full contents
    step("R7", 1'b1, 2, 1, 1'b0);
    step("R7", 1'b1, 2, 3, 1'b0);
    // R5: request beyond valid count
    step("R5", 1'b0, 0, 7, 1'b0);
    step("R5", 1'b0, 0, 2, 1'b0);
    // R3: oversize counts
    step("R3", 1'b1, 5, 0, 1'b0);
    step("R3", 1'b1, 7, 0, 1'b0);
    // R8: flush beats fetch and dispatch
    step("R8", 1'b1, 4, 2, 1'b1);
    step("R8", 1'b0, 0, 0, 1'b0);
    // R9: consume everything at odd tail, next group starts at 0
    step("R9", 1'b1, 3, 0, 1'b0);
    step("R9", 1'b1, 2, 3, 1'b0);
    step("R9", 1'b1, 4, 1, 1'b0);
    step("R7", 1'b1, 3, 2, 1'b0);
    step("R7", 1'b1, 2, 4, 1'b0);
    // Random mix across all requirements (R2 R4 R5 R6 R7)
    for (int n = 0; n < 3000; n++) begin
      bit fv = ($urandom % 4) != 0;
      int fc = ($urandom % 16 == 0) ? 5 + $urandom % 3 : $urandom % 5;
      int tk = $urandom % 8;
      bit fl = ($urandom % 64) == 0;
      step("R5", fv, fc, tk, fl);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule